// File: doc/BRIEF.md
# Floating-point vector range unit

This block takes two vectors of IEEE-754 elements and, lane by lane, picks one operand of each pair. It can pick the signed minimum, the signed maximum, the operand of smaller magnitude or the operand of larger magnitude. It then applies a sign rule to the chosen value. One 4-bit control word, shared by every lane, sets both the pick and the sign rule. A per-lane mask selects which lanes are written. A lane with its mask bit clear takes either a value from a separate source vector or all zeros. A scalar mode computes lane 0 only and copies the upper lanes of `in_a` to the output.

The element width is a parameter: 32 for single precision or 64 for double precision. The lane count is the vector width divided by the element width. Results come out of a single output register. The input side and the output side are valid/ready streams. A result is accepted when `in_valid` and `in_ready` are both high on a rising clock edge, and it appears on the next edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word and `out_valid` hold their values. Flags, exceptions, rounding and denormal flushing are not modelled.

Top module: `fp_range_unit`

## Requirements
- R1: When `in_ctrl[1:0]`=0 the lane gives the signed minimum, and when it is 1 the lane gives the signed maximum. If the two operands compare equal, including +0 against -0, the result is `b`. If either operand is a NaN (exponent all ones and a nonzero fraction), the result is `b`.
- R2: When `in_ctrl[1:0]`=2 the lane gives `a` if |a| <= |b| and `b` otherwise. The magnitude of an element is the element with its top bit cleared, compared as an unsigned integer, so a tie gives `a`.
- R3: When `in_ctrl[1:0]`=3 the lane gives `b` if |b| >= |a| and `a` otherwise, so a tie gives `b`.
- R4: `in_ctrl[3:2]` rewrites the sign bit (the top bit of the element) of the picked value. 00 copies the sign of `a`, 01 keeps the sign unchanged, 10 clears the sign and 11 sets it.
- R5: When `in_zero_mode`=0, a lane whose bit in `in_mask` is 0 (lane 0 is bit 0) outputs the matching lane of `in_src`.
- R6: When `in_zero_mode`=1, a lane whose mask bit is 0 outputs all zeros.
- R7: When `in_scalar`=1, lane 0 is computed under mask bit 0. Every other lane outputs the matching lane of `in_a`, whatever the mask and the source vector hold.
- R8: An input accepted on a clock edge appears on `out_data` with `out_valid` high right after that edge. With no new input and the output being drained, `out_valid` falls.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold, and `in_ready` is 0.
- R10: While `rst` is high, and right after it is released, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_a | input | VEC_W | First operand vector |
| in_b | input | VEC_W | Second operand vector |
| in_src | input | VEC_W | Merge source vector |
| in_mask | input | LANES | Lane write mask, lane 0 in bit 0 |
| in_ctrl | input | 4 | [1:0] pick mode, [3:2] sign rule |
| in_zero_mode | input | 1 | 1: masked lanes output zero; 0: masked lanes take `in_src` |
| in_scalar | input | 1 | Compute lane 0 only; upper lanes copy `in_a` |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | VEC_W | Result vector |

## Verification
The assertions assume that `rst` is held high for at least one edge before traffic starts. They also assume that the control, mask and operand inputs are known whenever `in_valid` is high. The operand-pick check relates each written lane to the operands captured on the accepting edge, so it holds only if the stimulus presents the whole input word in the accepting cycle. The stimulus changes inputs only at falling edges. It keeps a word on the inputs until that word is taken. It throttles `out_ready` at random, and it mixes zeros of both signs, NaNs, infinities and exact magnitude ties with random bit patterns, so that every pick rule and sign rule meets its boundary cases.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    PICK_MIN    = 2'd0,
    PICK_MAX    = 2'd1,
    PICK_SMALLM = 2'd2,
    PICK_LARGEM = 2'd3
  } pick_e;

  typedef enum logic [1:0] {
    SIGN_OF_A  = 2'd0,
    SIGN_KEEP  = 2'd1,
    SIGN_CLEAR = 2'd2,
    SIGN_SET   = 2'd3
  } sign_e;

  function automatic int exp_bits(input int width);
    return (width == 64) ? 11 : 8;
  endfunction
endpackage

// File: rtl/fpr_lane.sv
module fpr_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0]       op_a,
  input  logic [W-1:0]       op_b,
  input  fpr_pkg::pick_e     pick,
  input  fpr_pkg::sign_e     sign_rule,
  output logic [W-1:0]       lane_res
);
  import fpr_pkg::*;
  localparam int EW = exp_bits(W);
  localparam int MW = W - 1 - EW;

  logic [W-2:0] mag_a, mag_b;
  logic         sa, sb, nan_a, nan_b, both_zero, a_below_b, b_below_a;
  logic [W-1:0] chosen;

  assign mag_a = op_a[W-2:0];
  assign mag_b = op_b[W-2:0];
  assign sa    = op_a[W-1];
  assign sb    = op_b[W-1];
  assign nan_a = (&op_a[W-2:MW]) && (|op_a[MW-1:0]);
  assign nan_b = (&op_b[W-2:MW]) && (|op_b[MW-1:0]);
  assign both_zero = (mag_a == '0) && (mag_b == '0);

  // Signed ordering on sign-magnitude encodings; zero pair handled above it.
  always_comb begin
    case ({sa, sb})
      2'b00:   begin a_below_b = mag_a < mag_b; b_below_a = mag_b < mag_a; end
      2'b11:   begin a_below_b = mag_a > mag_b; b_below_a = mag_b > mag_a; end
      2'b10:   begin a_below_b = 1'b1;          b_below_a = 1'b0;          end
      default: begin a_below_b = 1'b0;          b_below_a = 1'b1;          end
    endcase
  end

  always_comb begin
    chosen = op_b;
    unique case (pick)
      PICK_MIN:    if (!(nan_a || nan_b || both_zero) && a_below_b) chosen = op_a;
      PICK_MAX:    if (!(nan_a || nan_b || both_zero) && b_below_a) chosen = op_a;
      PICK_SMALLM: chosen = (mag_a <= mag_b) ? op_a : op_b;
      PICK_LARGEM: chosen = (mag_b >= mag_a) ? op_b : op_a;
      default:     chosen = op_b;
    endcase
  end

  always_comb begin
    lane_res = chosen;
    unique case (sign_rule)
      SIGN_OF_A:  lane_res[W-1] = sa;
      SIGN_KEEP:  lane_res[W-1] = chosen[W-1];
      SIGN_CLEAR: lane_res[W-1] = 1'b0;
      SIGN_SET:   lane_res[W-1] = 1'b1;
      default:    lane_res[W-1] = chosen[W-1];
    endcase
  end
endmodule

// File: rtl/fpr_writeback.sv
module fpr_writeback #(
  parameter int W = 32
) (
  input  logic [W-1:0] lane_res,
  input  logic [W-1:0] lane_a,
  input  logic [W-1:0] lane_src,
  input  logic         enable,
  input  logic         zero_mode,
  input  logic         pass_a,
  output logic [W-1:0] lane_out
);
  always_comb begin
    if (pass_a)         lane_out = lane_a;
    else if (enable)    lane_out = lane_res;
    else if (zero_mode) lane_out = '0;
    else                lane_out = lane_src;
  end
endmodule

// File: rtl/fp_range_unit.sv
module fp_range_unit #(
  parameter  int ELEM_W = 32,
  parameter  int VEC_W  = 128,
  localparam int LANES  = VEC_W / ELEM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  in_a,
  input  logic [VEC_W-1:0]  in_b,
  input  logic [VEC_W-1:0]  in_src,
  input  logic [LANES-1:0]  in_mask,
  input  logic [3:0]        in_ctrl,
  input  logic              in_zero_mode,
  input  logic              in_scalar,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_data
);
  import fpr_pkg::*;
  localparam int W = ELEM_W;

  logic [VEC_W-1:0] next_word;
  logic             take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [W-1:0] a_i, b_i, r_i, w_i;
    assign a_i = in_a[i*W +: W];
    assign b_i = in_b[i*W +: W];

    fpr_lane #(.W(W)) u_core (
      .op_a      (a_i),
      .op_b      (b_i),
      .pick      (pick_e'(in_ctrl[1:0])),
      .sign_rule (sign_e'(in_ctrl[3:2])),
      .lane_res  (r_i)
    );

    fpr_writeback #(.W(W)) u_wb (
      .lane_res  (r_i),
      .lane_a    (a_i),
      .lane_src  (in_src[i*W +: W]),
      .enable    (in_mask[i]),
      .zero_mode (in_zero_mode),
      .pass_a    (in_scalar && (i != 0)),
      .lane_out  (w_i)
    );

    assign next_word[i*W +: W] = w_i;

    // Written lane carries the magnitude bits of one of its operands.
    assert_pick_operand_R1: assert property (@(posedge clk) disable iff (rst)
      (take && in_mask[i] && (!in_scalar || i == 0)) |=>
      ((out_data[i*W +: W-1] == $past(in_a[i*W +: W-1])) ||
       (out_data[i*W +: W-1] == $past(in_b[i*W +: W-1]))));

    assert_sign_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (take && in_mask[i] && (!in_scalar || i == 0) && in_ctrl[3:2] == 2'b10) |=>
      (out_data[i*W + W - 1] == 1'b0));

    assert_sign_set_R4: assert property (@(posedge clk) disable iff (rst)
      (take && in_mask[i] && (!in_scalar || i == 0) && in_ctrl[3:2] == 2'b11) |=>
      (out_data[i*W + W - 1] == 1'b1));

    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
      (take && !in_mask[i] && in_zero_mode && (!in_scalar || i == 0)) |=>
      (out_data[i*W +: W] == '0));

    if (i > 0) begin : g_pass
      assert_scalar_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (take && in_scalar) |=> (out_data[i*W +: W] == $past(in_a[i*W +: W])));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_data  <= next_word;
    end
  end

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_drain_empties_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/tb_fp_range_unit.sv
`timescale 1ns/1ps
module tb_fp_range_unit;
  localparam int W = 32;
  localparam int L = 4;
  localparam int V = W * L;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [V-1:0] in_a = '0, in_b = '0, in_src = '0, out_data;
  logic [L-1:0] in_mask = '0;
  logic [3:0]   in_ctrl = '0;
  logic in_zero_mode = 1'b0, in_scalar = 1'b0;

  always #2.5 clk = ~clk;

  fp_range_unit #(.ELEM_W(W), .VEC_W(V)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_src(in_src), .in_mask(in_mask),
    .in_ctrl(in_ctrl), .in_zero_mode(in_zero_mode), .in_scalar(in_scalar),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  typedef struct {
    logic [V-1:0] exp;
    logic [3:0]   ctrl;
    logic [L-1:0] mask;
    logic         zm, sc;
  } item_t;

  item_t        q[$];
  int           checks = 0, fails = 0;
  bit           rdy_random = 0, accepted = 0, hold_pending = 0, done = 0;
  logic [V-1:0] held;

  task automatic check(input bit ok, input string tag, input logic [V-1:0] act, input logic [V-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_lane(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
    longint ka, kb;
    logic [W-1:0] r;
    bit nan;
    ka  = a[W-1] ? -longint'(a[W-2:0]) : longint'(a[W-2:0]);
    kb  = b[W-1] ? -longint'(b[W-2:0]) : longint'(b[W-2:0]);
    nan = (a[W-2:0] > 31'h7F800000) || (b[W-2:0] > 31'h7F800000);
    case (c[1:0])
      2'd0: r = (!nan && ka < kb) ? a : b;
      2'd1: r = (!nan && ka > kb) ? a : b;
      2'd2: r = (a[W-2:0] <= b[W-2:0]) ? a : b;
      default: r = (b[W-2:0] >= a[W-2:0]) ? b : a;
    endcase
    case (c[3:2])
      2'd0: r[W-1] = a[W-1];
      2'd2: r[W-1] = 1'b0;
      2'd3: r[W-1] = 1'b1;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [V-1:0] ref_vec();
    logic [V-1:0] r;
    for (int i = 0; i < L; i++) begin
      if (in_scalar && i > 0)  r[i*W +: W] = in_a[i*W +: W];
      else if (in_mask[i])     r[i*W +: W] = ref_lane(in_a[i*W +: W], in_b[i*W +: W], in_ctrl);
      else if (in_zero_mode)   r[i*W +: W] = '0;
      else                     r[i*W +: W] = in_src[i*W +: W];
    end
    return r;
  endfunction

  function automatic string lane_tag(input item_t it, input int i);
    string t;
    if (it.sc && i > 0)  return "R7";
    if (!it.mask[i])     return it.zm ? "R6" : "R5";
    case (it.ctrl[1:0])
      2'd2: t = "R2";
      2'd3: t = "R3";
      default: t = "R1";
    endcase
    if (it.ctrl[3:2] != 2'd1) t = {t, "/R4"};
    return t;
  endfunction

  // Evaluate the upcoming edge's handshakes, then advance to the next falling edge.
  task automatic step();
    if (rdy_random) out_ready = ($urandom % 4) != 0;
    #0.1;
    if (hold_pending) begin
      check(out_valid && out_data == held, "R9 hold", out_data, held);
      hold_pending = 0;
    end
    if (out_valid && !out_ready) begin
      held = out_data;
      hold_pending = 1;
      check(!in_ready, "R9 ready", V'(in_ready), '0);
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) check(0, "R8 unexpected output", out_data, '0);
      else begin
        item_t it = q.pop_front();
        for (int i = 0; i < L; i++)
          check(out_data[i*W +: W] == it.exp[i*W +: W], lane_tag(it, i),
                V'(out_data[i*W +: W]), V'(it.exp[i*W +: W]));
      end
    end
    accepted = 0;
    if (in_valid && in_ready) begin
      item_t n;
      n.exp = ref_vec(); n.ctrl = in_ctrl; n.mask = in_mask; n.zm = in_zero_mode; n.sc = in_scalar;
      q.push_back(n);
      accepted = 1;
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [V-1:0] a, input logic [V-1:0] b, input logic [V-1:0] s,
                      input logic [L-1:0] m, input logic [3:0] c, input logic zm, input logic sc);
    in_a = a; in_b = b; in_src = s; in_mask = m; in_ctrl = c;
    in_zero_mode = zm; in_scalar = sc; in_valid = 1'b1;
    do step(); while (!accepted);
    in_valid = 1'b0;
  endtask

  function automatic logic [W-1:0] pick_elem();
    case ($urandom % 8)
      0: return 32'h00000000;
      1: return 32'h80000000;
      2: return 32'h7FC00001;
      3: return 32'h7F800000;
      4: return 32'h3F800000;
      5: return 32'hBF800000;
      default: return $urandom;
    endcase
  endfunction

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [V-1:0] ta, tb_v, ts;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R10 in reset", V'({out_valid, in_ready}), V'(2'b01));
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R10 after reset", V'({out_valid, in_ready}), V'(2'b01));

    // R8: single word, latency of one edge, then drain.
    ta   = {32'h40000000, 32'hBF800000, 32'h7FC00000, 32'h3F800000};
    tb_v = {32'h3F800000, 32'hC0000000, 32'h3F800000, 32'h40000000};
    send(ta, tb_v, '0, 4'hF, 4'h4, 1'b0, 1'b0);
    check(out_valid, "R8 latency", V'(out_valid), V'(1));
    step();
    check(!out_valid, "R8 drain", V'(out_valid), V'(0));

    // R1..R4: every control value on ties, signed zeros and NaNs.
    ta   = {32'h80000000, 32'h3F800000, 32'hC0400000, 32'h7FC00000};
    tb_v = {32'h00000000, 32'hBF800000, 32'h40400000, 32'h3F800000};
    for (int c = 0; c < 16; c++) send(ta, tb_v, '1, 4'hF, 4'(c), 1'b0, 1'b0);
    ta   = {32'hC0000000, 32'h40000000, 32'h3F800000, 32'hBF800000};
    tb_v = {32'h3F800000, 32'hC0400000, 32'h3F800000, 32'h00000000};
    for (int c = 0; c < 16; c++) send(ta, tb_v, '1, 4'hF, 4'(c), 1'b0, 1'b0);

    // R5/R6: merge and zero masking.
    ts = {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444};
    send(ta, tb_v, ts, 4'b0101, 4'h5, 1'b0, 1'b0);
    send(ta, tb_v, ts, 4'b1010, 4'h5, 1'b1, 1'b0);
    send(ta, tb_v, ts, 4'b0000, 4'h2, 1'b1, 1'b0);

    // R7: scalar mode, both states of mask bit 0.
    send(ta, tb_v, ts, 4'b0001, 4'h3, 1'b0, 1'b1);
    send(ta, tb_v, ts, 4'b1110, 4'h3, 1'b0, 1'b1);
    send(ta, tb_v, ts, 4'b1110, 4'h3, 1'b1, 1'b1);
    step(); step();

    // Random traffic with a throttled consumer (R9).
    rdy_random = 1;
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < L; i++) begin
        ta[i*W +: W]   = pick_elem();
        tb_v[i*W +: W] = (($urandom % 4) == 0) ? (ta[i*W +: W] ^ 32'h80000000) : pick_elem();
        ts[i*W +: W]   = $urandom;
      end
      send(ta, tb_v, ts, 4'($urandom), 4'($urandom), 1'($urandom), (($urandom % 5) == 0));
    end
    for (int k = 0; k < 50 && q.size() != 0; k++) step();
    rdy_random = 0; out_ready = 1'b1;
    step(); step();
    check(q.size() == 0 && !out_valid, "R8 final drain", V'(q.size()), '0);
    finish_run();
  end
endmodule